// File: doc/BRIEF.md
# Two-Register Shrinking Keystream Generator

This block produces a keystream bit by bit from two small Fibonacci shift registers that always advance together. The longer register, 6 stages, supplies candidate data bits. The shorter register, 5 stages, supplies selection bits. On every step one selection bit and one data bit are consumed as a pair. If the selection bit is 1, the data bit is emitted. If it is 0, the data bit is discarded.

Because of this, the output strobe is irregular and depends on the register contents. A consumer should treat `ks_valid` as a qualifier, not as a fixed-rate clock.

There is no back-pressure path. The consumer sets the pace through `step_en`: it raises `step_en` only when it can accept a possible bit in the following cycle. Holding `step_en` low freezes the generator.

An optional seed port overwrites both registers in one cycle. Any all-zero seed is replaced by all ones, so neither register can lock up.

Top module: `shrink_keygen`

## Requirements
- R1: After reset, both registers hold all ones, and `ks_valid` and `ks_bit` are 0.
- R2: The selection register has 5 stages, numbered 1 to 5. Its output is stage 5. On a step, stage k+1 takes stage k, and stage 1 takes stage 3 XOR stage 5.
- R3: The data register has 6 stages, numbered 1 to 6. Its output is stage 6. On a step, it shifts in the same direction, and stage 1 takes stage 5 XOR stage 6. Seed bit k-1 loads stage k.
- R4: A step whose selection bit is 1 drives `ks_valid` to 1 in the next cycle, with `ks_bit` equal to the paired data bit.
- R5: A step whose selection bit is 0 drops its data bit. In the next cycle, `ks_valid` is 0 and `ks_bit` keeps its previous value.
- R6: In a cycle with neither `step_en` nor `load_en`, both registers hold their values. In the next cycle, `ks_valid` is 0 and `ks_bit` is unchanged.
- R7: `load_en` writes `seed_sel` and `seed_dat` into the registers, with an all-zero seed replaced by all ones. Load takes priority over `step_en`. In the next cycle, `ks_valid` is 0 and `ks_bit` is unchanged.
- R8: From the all-ones state, 1953 consecutive steps produce exactly 1008 valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance both registers by one position |
| load_en | input | 1 | Load both seeds; takes priority over step_en |
| seed_sel | input | 5 | Seed for the selection register |
| seed_dat | input | 6 | Seed for the data register |
| ks_bit | output | 1 | Emitted keystream bit, meaningful when ks_valid is 1 |
| ks_valid | output | 1 | One-cycle strobe marking an emitted bit |

## Verification
The assertions assume that `step_en` and `load_en` are known and are sampled only after reset has been released. They also assume that the consumer accepts every strobe, because there is no ready input.

The bench changes inputs only on falling edges and holds them for a full cycle. It mixes continuous stepping, gapped stepping, and loads issued together with a step. It also sweeps every seed pair, including the all-zero ones, so every path stays inside these assumptions.

// File: rtl/shrink_pkg.sv
package shrink_pkg;
  localparam int SEL_LEN = 5;
  localparam int SEL_TAP = 3;
  localparam int DAT_LEN = 6;
  localparam int DAT_TAP = 5;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } shrink_act_e;
endpackage

// File: rtl/shrink_lfsr.sv
module shrink_lfsr #(
  parameter int LEN = 5,
  parameter int TAP = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  shrink_pkg::shrink_act_e act,
  input  logic [LEN-1:0] seed,
  output logic           out_bit
);
  import shrink_pkg::*;

  localparam logic [LEN-1:0] ALL_ONES = {LEN{1'b1}};

  logic [LEN-1:0] stage_q;
  logic [LEN-1:0] seed_fix;
  logic           fb;

  assign seed_fix = (seed == '0) ? ALL_ONES : seed;
  assign fb       = stage_q[LEN-1] ^ stage_q[TAP-1];
  assign out_bit  = stage_q[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ALL_ONES;
    end else begin
      case (act)
        ACT_LOAD: stage_q <= seed_fix;
        ACT_STEP: stage_q <= {stage_q[LEN-2:0], fb};
        default:  stage_q <= stage_q;
      endcase
    end
  end

  assert_no_lockup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q != '0);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE) |=> $stable(stage_q));

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (stage_q[LEN-1:1] == $past(stage_q[LEN-2:0])));
endmodule

// File: rtl/shrink_select.sv
module shrink_select (
  input  logic clk,
  input  logic rst_n,
  input  shrink_pkg::shrink_act_e act,
  input  logic sel_bit,
  input  logic dat_bit,
  output logic ks_bit,
  output logic ks_valid
);
  import shrink_pkg::*;

  logic keep;

  assign keep = (act == ACT_STEP) && sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_valid <= 1'b0;
      ks_bit   <= 1'b0;
    end else begin
      ks_valid <= keep;
      if (keep) ks_bit <= dat_bit;
    end
  end

  assert_valid_from_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> ($past(act) == ACT_STEP));

  assert_bit_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ks_valid |-> $stable(ks_bit));

  assert_drop_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((act == ACT_STEP) && !sel_bit) |=> !ks_valid);
endmodule

// File: rtl/shrink_keygen.sv
module shrink_keygen #(
  parameter int SEL_LEN = shrink_pkg::SEL_LEN,
  parameter int SEL_TAP = shrink_pkg::SEL_TAP,
  parameter int DAT_LEN = shrink_pkg::DAT_LEN,
  parameter int DAT_TAP = shrink_pkg::DAT_TAP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic               load_en,
  input  logic [SEL_LEN-1:0] seed_sel,
  input  logic [DAT_LEN-1:0] seed_dat,
  output logic               ks_bit,
  output logic               ks_valid
);
  import shrink_pkg::*;

  shrink_act_e act;
  logic        sel_out;
  logic        dat_out;

  always_comb begin
    if (load_en)      act = ACT_LOAD;
    else if (step_en) act = ACT_STEP;
    else              act = ACT_IDLE;
  end

  shrink_lfsr #(.LEN(SEL_LEN), .TAP(SEL_TAP)) u_sel_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .seed   (seed_sel),
    .out_bit(sel_out)
  );

  shrink_lfsr #(.LEN(DAT_LEN), .TAP(DAT_TAP)) u_dat_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .seed   (seed_dat),
    .out_bit(dat_out)
  );

  shrink_select u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .sel_bit (sel_out),
    .dat_bit (dat_out),
    .ks_bit  (ks_bit),
    .ks_valid(ks_valid)
  );

  assert_load_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !ks_valid);
endmodule

// File: tb/test_shrink_keygen.sv
`timescale 1ns/1ps
module test_shrink_keygen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] seed_sel = '0;
  logic [5:0] seed_dat = '0;
  logic       ks_bit;
  logic       ks_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [4:0] m_sel;
  logic [5:0] m_dat;
  logic       m_bit;
  logic       m_val;

  always #2.5 clk = ~clk;

  shrink_keygen i_shrink_keygen (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
    .seed_sel(seed_sel), .seed_dat(seed_dat),
    .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  task automatic check(input string req, input logic act_v, input logic exp_v,
                       input logic act_b, input logic exp_b);
    total++;
    if (act_v !== exp_v || act_b !== exp_b) begin
      bad++;
      $display("FAIL %s: valid=%b bit=%b expected valid=%b bit=%b", req, act_v, act_b, exp_v, exp_b);
    end
  endtask

  // One cycle: drive at negedge, model, check at the next negedge.
  task automatic cyc(input logic st, input logic ld, input logic [4:0] ss, input logic [5:0] sd);
    string req;
    step_en = st; load_en = ld; seed_sel = ss; seed_dat = sd;
    if (ld) begin
      req = "R7";
      m_sel = (ss == 0) ? 5'h1f : ss;
      m_dat = (sd == 0) ? 6'h3f : sd;
      m_val = 1'b0;
    end else if (st) begin
      m_val = m_sel[4];
      req = m_val ? "R4" : "R5";
      if (m_val) m_bit = m_dat[5];
      m_sel = {m_sel[3:0], m_sel[4] ^ m_sel[2]};
      m_dat = {m_dat[4:0], m_dat[5] ^ m_dat[4]};
    end else begin
      req = "R6";
      m_val = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, ks_valid, m_val, ks_bit, m_bit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: valid=%b bit=%b expected run to end", ks_valid, ks_bit);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    m_sel = 5'h1f; m_dat = 6'h3f; m_bit = 1'b0; m_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", ks_valid, 1'b0, ks_bit, 1'b0);

    // Continuous stepping from the reset state: R2 and R3 sequences.
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 5'd0, 6'd0);

    // Gapped stepping: idle cycles hold state (R6).
    for (int i = 0; i < 300; i++) cyc((i % 3) != 0, 1'b0, 5'd0, 6'd0);

    // R3: with an all-ones selection seed, the first five data stages appear in order.
    cyc(1'b0, 1'b1, 5'h1f, 6'b101100);
    for (int k = 0; k < 5; k++) begin
      step_en = 1'b1; load_en = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R3", ks_valid, 1'b1, ks_bit, (6'b101100 >> (5 - k)) & 1'b1);
    end
    step_en = 1'b0;
    m_sel = 5'h1f; m_dat = 6'b101100;
    for (int k = 0; k < 5; k++) begin
      m_sel = {m_sel[3:0], m_sel[4] ^ m_sel[2]};
      m_dat = {m_dat[4:0], m_dat[5] ^ m_dat[4]};
    end
    m_bit = 1'b0;

    // R8: full joint period from all ones.
    cyc(1'b0, 1'b1, 5'd0, 6'd0);
    m_bit = ks_bit;
    cnt = 0;
    step_en = 1'b1; load_en = 1'b0;
    for (int i = 0; i < 1953; i++) begin
      @(posedge clk); @(negedge clk);
      if (ks_valid === 1'b1) cnt++;
    end
    step_en = 1'b0;
    total++;
    if (cnt != 1008) begin
      bad++;
      $display("FAIL R8: strobes=%0d expected=%0d", cnt, 1008);
    end
    @(negedge clk);
    m_sel = 5'h1f; m_dat = 6'h3f; m_val = 1'b0;
    m_bit = ks_bit;

    // Seed sweep with loads alone and loads issued together with a step (R7, R2).
    for (int s = 0; s < 32; s++) begin
      for (int d = 0; d < 64; d++) begin
        cyc((d % 2) == 1, 1'b1, s[4:0], d[5:0]);
        for (int k = 0; k < 9; k++) cyc(k != 4, 1'b0, 5'd0, 6'd0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule